// File: doc/BRIEF.md
# Segmented 32-bit Host Port

This block sits between a 32-bit host bus and the 128-bit registers of a wide associative search engine. The host runs cycles qualified by an active-low strobe. The block samples the strobe on the system clock. It captures the read/write select, the command/data select and the bus word in the clock cycle where it first sees the strobe low. It performs the cycle's bookkeeping in the cycle where it first sees the strobe high again. The two selects give four cycle types: command write, data write, command read and data read.

Data cycles move one 32-bit segment at a time. Two segment counters in the active segment control register decide which slice is touched. The destination counter is used for writes into the comparand or mask 1. The source counter is used for reads from the comparand or mask 1. When the destination counter reaches its end segment, a comparand or mask write raises a one-cycle compare request.

Command words do three jobs:
- They write configuration registers in a single cycle.
- They set up a two-cycle register read, which is answered by the next command read.
- They swap between two complete sets of configuration registers.

Each set holds control, segment control, address, mask 1 and the source/destination select. The comparand and the page register are shared by both sets.

Top module: `seg_host_port`

## Requirements
- R1: In a data write cycle, the bus word is stored into segment k of the destination, where k is the destination count and segment k occupies bits 32k+31..32k. The destination is the comparand when select bit 0 is 0 and mask 1 when it is 1. In a data read cycle, the bus returns segment k of the source, where k is the source count. The source is the comparand when select bit 1 is 0 and mask 1 when it is 1.
- R2: The bus output enable is high only in a read cycle, from the clock after the strobe is seen low until the clock after it is seen high. While it is low, the output word is zero.
- R3: Each counter advances once per data cycle of its own kind, on the strobe's rising edge. It counts from its start segment to its end segment and then wraps to its start.
- R3 (field layout): The segment control fields are: bits 1..0 destination start, 3..2 destination end, 5..4 source start, 7..6 source end, 9..8 destination count, 11..10 source count.
- R4: `cmp_req` pulses for one clock in each of these cases:
  - a data write at destination count equal to destination end;
  - a control register write;
  - a compare command (opcode 4 in bits 31..28).
- R5: A command with opcode 1 in bits 31..28 and flag bit 27 set to 1 writes bits 15..0 into the register named by bits 26..24. The register codes are 0 control, 1 segment control, 2 address, 3 page, 4 source/destination select. Writing segment control also loads both counts from their start fields.
- R6: Opcode 1 with bit 27 cleared arms a read of the named register. If the next cycle is a command read, it returns that register in bits 15..0 and status bits 31..16 in bits 31..16.
- R7: Any cycle other than a command read cancels an armed read. A command read with no armed read returns the full 32-bit status input.
- R8: A register read of the page register returns zero in bits 31..16.
- R9: Opcode 2 makes the set named by bit 0 active and pulses `match_clr`. All set registers and outputs then come from that set, and the other set keeps its contents.
- R10: Opcode 5 steps the active address register: +1 when control bits 1..0 are 01, −1 when they are 10, unchanged otherwise.
- R11: Opcode 3 returns both counts of the active set to their start segments in a single cycle.
- R12: After reset, all registers are zero, set 0 is active and the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strb_n | input | 1 | Active-low cycle strobe |
| wr_n | input | 1 | Low selects a write cycle |
| cmd_n | input | 1 | Low selects a command cycle |
| dq_in | input | 32 | Bus word from the host |
| status_in | input | 32 | Status word from the search engine |
| dq_out | output | 32 | Bus word to the host |
| dq_oe | output | 1 | Bus output enable |
| comparand | output | 128 | Comparand register |
| mask1 | output | 128 | Active mask 1 |
| ctrl | output | 16 | Active control register |
| addr | output | 16 | Active address register |
| active_set | output | 1 | Active configuration set |
| cmp_req | output | 1 | One-cycle compare request |
| match_clr | output | 1 | One-cycle match clear on a set swap |

## Verification
The bench builds the block with its defaults: a 32-bit bus, four segments and 16-bit configuration registers. With these values a full four-segment comparand load reaches terminal count at segment 3. A fifth read then shows the wrap back to the start segment. The same widths let the bench check the address increment across the 0x00FF/0x0100 boundary. They also cover the armed-read and cancel sequence, and the separation between the two register sets.

// File: rtl/seg_host_port.sv
module seg_host_port #(
  parameter int BUS_W = 32,
  parameter int NSEG  = 4,
  parameter int RW    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strb_n,
  input  logic                  wr_n,
  input  logic                  cmd_n,
  input  logic [BUS_W-1:0]      dq_in,
  input  logic [BUS_W-1:0]      status_in,
  output logic [BUS_W-1:0]      dq_out,
  output logic                  dq_oe,
  output logic [NSEG*BUS_W-1:0] comparand,
  output logic [NSEG*BUS_W-1:0] mask1,
  output logic [RW-1:0]         ctrl,
  output logic [RW-1:0]         addr,
  output logic                  active_set,
  output logic                  cmp_req,
  output logic                  match_clr
);
  localparam int WW = NSEG * BUS_W;
  localparam int SW = $clog2(NSEG);
  localparam int HW = BUS_W - RW;

  logic [RW-1:0] ctrl_r [2];
  logic [RW-1:0] segc_r [2];
  logic [RW-1:0] addr_r [2];
  logic [RW-1:0] sds_r  [2];
  logic [WW-1:0] mask_r [2];
  logic [WW-1:0] cmp_r;
  logic [RW-1:0] page_r;
  logic          sel, s_q, rd_act, cyc_cmd, cyc_dw, cyc_dr;
  logic          rd_pend, serve;
  logic [2:0]    rd_id, srv_id;
  logic [RW-1:0] segc_ld, regval;

  wire       fall = s_q & ~strb_n;
  wire       rise = ~s_q & strb_n;
  wire [3:0] op   = dq_in[31:28];
  wire       flag = dq_in[27];
  wire [2:0] rid  = dq_in[26:24];
  wire       cw   = fall & ~wr_n & ~cmd_n;
  wire       dw   = fall & ~wr_n & cmd_n;
  wire       cr   = fall & wr_n & ~cmd_n;
  wire       regwr = cw && op == 4'd1 && flag;
  wire       rdset = cw && op == 4'd1 && !flag;

  wire [SW-1:0] d_st = segc_r[sel][0*SW +: SW];
  wire [SW-1:0] d_en = segc_r[sel][1*SW +: SW];
  wire [SW-1:0] s_st = segc_r[sel][2*SW +: SW];
  wire [SW-1:0] s_en = segc_r[sel][3*SW +: SW];
  wire [SW-1:0] d_c  = segc_r[sel][4*SW +: SW];
  wire [SW-1:0] s_c  = segc_r[sel][5*SW +: SW];

  function automatic logic [SW-1:0] nxt(input logic [SW-1:0] c, st, en);
    return (c == en) ? st : c + 1'b1;
  endfunction

  always_comb begin
    segc_ld = dq_in[RW-1:0];
    segc_ld[4*SW +: SW] = dq_in[0*SW +: SW];
    segc_ld[5*SW +: SW] = dq_in[2*SW +: SW];
    case (srv_id)
      3'd0: regval = ctrl_r[sel];
      3'd1: regval = segc_r[sel];
      3'd2: regval = addr_r[sel];
      3'd3: regval = page_r;
      3'd4: regval = sds_r[sel];
      default: regval = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        ctrl_r[i] <= '0; segc_r[i] <= '0; addr_r[i] <= '0;
        sds_r[i] <= '0; mask_r[i] <= '0;
      end
      cmp_r <= '0; page_r <= '0; sel <= 1'b0; s_q <= 1'b1;
      rd_act <= 1'b0; cyc_cmd <= 1'b0; cyc_dw <= 1'b0; cyc_dr <= 1'b0;
      rd_pend <= 1'b0; serve <= 1'b0; rd_id <= '0; srv_id <= '0;
      cmp_req <= 1'b0; match_clr <= 1'b0;
    end else begin
      s_q <= strb_n;
      cmp_req <= 1'b0;
      match_clr <= 1'b0;
      if (fall) begin
        rd_act  <= wr_n;
        cyc_cmd <= ~cmd_n;
        cyc_dw  <= ~wr_n & cmd_n;
        cyc_dr  <= wr_n & cmd_n;
        rd_pend <= rdset;
        rd_id   <= rid;
        serve   <= cr & rd_pend;
        srv_id  <= rd_id;
      end
      if (dw) begin
        if (sds_r[sel][0]) mask_r[sel][d_c*BUS_W +: BUS_W] <= dq_in;
        else               cmp_r[d_c*BUS_W +: BUS_W] <= dq_in;
      end
      if (regwr)
        case (rid)
          3'd0: begin ctrl_r[sel] <= dq_in[RW-1:0]; cmp_req <= 1'b1; end
          3'd1: segc_r[sel] <= segc_ld;
          3'd2: addr_r[sel] <= dq_in[RW-1:0];
          3'd3: page_r <= dq_in[RW-1:0];
          3'd4: sds_r[sel] <= dq_in[RW-1:0];
          default: ;
        endcase
      if (cw)
        case (op)
          4'd2: begin sel <= dq_in[0]; match_clr <= 1'b1; end
          4'd3: begin
            segc_r[sel][4*SW +: SW] <= d_st;
            segc_r[sel][5*SW +: SW] <= s_st;
          end
          4'd4: cmp_req <= 1'b1;
          4'd5:
            if (ctrl_r[sel][1:0] == 2'b01)      addr_r[sel] <= addr_r[sel] + RW'(1);
            else if (ctrl_r[sel][1:0] == 2'b10) addr_r[sel] <= addr_r[sel] - RW'(1);
          default: ;
        endcase
      if (rise) begin
        rd_act <= 1'b0;
        if (cyc_dw) begin
          segc_r[sel][4*SW +: SW] <= nxt(d_c, d_st, d_en);
          if (d_c == d_en) cmp_req <= 1'b1;
        end
        if (cyc_dr) segc_r[sel][5*SW +: SW] <= nxt(s_c, s_st, s_en);
      end
    end
  end

  always_comb begin
    dq_out = '0;
    if (rd_act) begin
      if (cyc_cmd) begin
        if (serve) dq_out = {(srv_id == 3'd3) ? {HW{1'b0}} : status_in[BUS_W-1:RW], regval};
        else       dq_out = status_in;
      end else if (sds_r[sel][1]) dq_out = mask_r[sel][s_c*BUS_W +: BUS_W];
      else                        dq_out = cmp_r[s_c*BUS_W +: BUS_W];
    end
  end

  assign dq_oe      = rd_act;
  assign comparand  = cmp_r;
  assign mask1      = mask_r[sel];
  assign ctrl       = ctrl_r[sel];
  assign addr       = addr_r[sel];
  assign active_set = sel;

  assert_oe_in_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !s_q);
  assert_swap_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    active_set != $past(active_set) |-> match_clr);
  assert_serve_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serve) |-> $past(rd_pend));
  assert_ctrl_compare_R4: assert property (@(posedge clk) disable iff (!rst_n)
    regwr && rid == 3'd0 |=> cmp_req);
endmodule

// File: tb/seg_host_port_test.sv
`timescale 1ns/1ps
module seg_host_port_test;
  logic clk = 0, rst_n = 0, strb_n = 1, wr_n = 1, cmd_n = 1;
  logic [31:0] dq_in = '0, status_in = 32'hABCD1234, dq_out;
  logic dq_oe, active_set, cmp_req, match_clr;
  logic [127:0] comparand, mask1;
  logic [15:0] ctrl, addr;
  int n_chk = 0, n_fail = 0, n_cmp = 0, n_clr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  seg_host_port uut (.clk(clk), .rst_n(rst_n), .strb_n(strb_n), .wr_n(wr_n), .cmd_n(cmd_n),
    .dq_in(dq_in), .status_in(status_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .comparand(comparand), .mask1(mask1), .ctrl(ctrl), .addr(addr),
    .active_set(active_set), .cmp_req(cmp_req), .match_clr(match_clr));

  always @(posedge clk) begin
    if (rst_n && cmp_req) n_cmp++;
    if (rst_n && match_clr) n_clr++;
  end

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic c, input logic [31:0] d,
                     output logic [31:0] rd, output logic oe);
    @(negedge clk); strb_n = 0; wr_n = w; cmd_n = c; dq_in = d;
    @(negedge clk); @(negedge clk);
    rd = dq_out; oe = dq_oe;
    strb_n = 1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // {wr_n, cmd_n, chk, req, data, expected}
  localparam int NV = 37;
  localparam logic [70:0] VEC [NV] = '{
    {3'b000, 4'd5,  32'h190000CC, 32'h0},        // R5 segment control
    {3'b010, 4'd1,  32'h11111111, 32'h0},
    {3'b010, 4'd1,  32'h22222222, 32'h0},
    {3'b010, 4'd1,  32'h33333333, 32'h0},
    {3'b010, 4'd1,  32'h44444444, 32'h0},
    {3'b111, 4'd1,  32'h0, 32'h11111111},        // R1
    {3'b111, 4'd3,  32'h0, 32'h22222222},        // R3
    {3'b111, 4'd3,  32'h0, 32'h33333333},
    {3'b111, 4'd3,  32'h0, 32'h44444444},
    {3'b111, 4'd3,  32'h0, 32'h11111111},        // R3 wrap
    {3'b000, 4'd6,  32'h11000000, 32'h0},
    {3'b101, 4'd6,  32'h0, 32'hABCD04CC},        // R6
    {3'b000, 4'd5,  32'h1B005A5A, 32'h0},
    {3'b000, 4'd8,  32'h13000000, 32'h0},
    {3'b101, 4'd8,  32'h0, 32'h00005A5A},        // R8
    {3'b000, 4'd7,  32'h10000000, 32'h0},
    {3'b111, 4'd7,  32'h0, 32'h22222222},
    {3'b101, 4'd7,  32'h0, 32'hABCD1234},        // R7 cancelled
    {3'b000, 4'd10, 32'h18000001, 32'h0},
    {3'b000, 4'd10, 32'h1A0000FE, 32'h0},
    {3'b000, 4'd10, 32'h50000000, 32'h0},
    {3'b000, 4'd10, 32'h50000000, 32'h0},
    {3'b000, 4'd10, 32'h12000000, 32'h0},
    {3'b101, 4'd10, 32'h0, 32'hABCD0100},        // R10 increment
    {3'b000, 4'd10, 32'h18000002, 32'h0},
    {3'b000, 4'd10, 32'h50000000, 32'h0},
    {3'b000, 4'd10, 32'h12000000, 32'h0},
    {3'b101, 4'd10, 32'h0, 32'hABCD00FF},        // R10 decrement
    {3'b111, 4'd11, 32'h0, 32'h33333333},
    {3'b000, 4'd11, 32'h30000000, 32'h0},
    {3'b111, 4'd11, 32'h0, 32'h11111111},        // R11
    {3'b000, 4'd9,  32'h20000001, 32'h0},
    {3'b000, 4'd9,  32'h10000000, 32'h0},
    {3'b101, 4'd9,  32'h0, 32'hABCD0000},        // R9 set 1
    {3'b000, 4'd9,  32'h20000000, 32'h0},
    {3'b000, 4'd9,  32'h10000000, 32'h0},
    {3'b101, 4'd9,  32'h0, 32'hABCD0002}         // R9 set 0 kept
  };

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic oe;
    repeat (4) @(negedge clk);
    check("R12 oe", dq_oe, 0);
    check("R12 comparand", comparand, 0);
    check("R12 set", active_set, 0);
    check("R12 ctrl", ctrl, 0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      bus(VEC[i][70], VEC[i][69], VEC[i][63:32], rd, oe);
      if (VEC[i][68]) check($sformatf("R%0d vector %0d", VEC[i][67:64], i), rd, VEC[i][31:0]);
    end
    check("R1 comparand", comparand, {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111});
    check("R4 compares", n_cmp, 3);
    check("R9 clears", n_clr, 2);
    bus(0, 0, 32'h1C000001, rd, oe);
    check("R2 oe write", oe, 0);
    for (int k = 0; k < 4; k++) bus(0, 1, 32'hA0 + k, rd, oe);
    check("R1 mask", mask1, {32'hA3, 32'hA2, 32'hA1, 32'hA0});
    check("R1 comparand kept", comparand, {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111});
    check("R4 mask terminal", n_cmp, 4);
    bus(0, 0, 32'h40000000, rd, oe);
    check("R4 command", n_cmp, 5);
    bus(1, 1, 32'h0, rd, oe);
    check("R2 oe read", oe, 1);
    check("R2 idle", {dq_oe, dq_out}, 0);
    bus(0, 0, 32'h20000001, rd, oe);
    check("R9 set1 mask", mask1, 0);
    check("R9 active", active_set, 1);
    bus(0, 0, 32'h20000000, rd, oe);
    check("R9 set0 mask", mask1, {32'hA3, 32'hA2, 32'hA1, 32'hA0});
    check("R9 clears", n_clr, 4);
    finish_run();
  end
endmodule